// File: doc/BRIEF.md
# Data-side memory access scoreboard

This block checks the data-side traffic of a processor core against a reference model. The core's bus monitor pushes every observed access into a small in-order queue. Each entry carries a word-aligned address, a load or store flag, four byte enables, the data word, an error flag and two flags that mark the first or second half of a split misaligned access. The reference model then presents its own expected accesses one at a time. Each has a byte address, a length of one to four bytes, a direction and up to four data bytes. For each one the block compares against the oldest queued entry and reports ok, check-failed or bus-error. On success it retires the entries that were matched.

A misaligned observed access is matched piecewise. The reference model may split it into several small accesses. The block accumulates the byte lanes seen so far, and it retires the entry only when the accumulated lanes cover its enables exactly. When a split access that crosses a word boundary carries an error, the pair of entries is retired together, because no further accesses will arrive for its second half.

Top module: `dside_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, res_valid and overflow are 0 and the queue is empty.
- R2: Each cycle with exp_valid high yields res_valid high in exactly the next cycle. res_valid is low otherwise. res_code is 0 for ok, 1 for check-failed and 2 for bus-error.
- R3: An expected access that arrives while the queue is empty gives check-failed.
- R4: An expected access whose length is 0 or above 4, or whose bytes would cross a 32-bit boundary (addr[1:0] + len > 4), gives check-failed.
- R5: The head entry fails the check when its address differs from the expected address with bits [1:0] cleared, or when its direction differs. Any check-failed leaves the queue and the accumulated lanes unchanged.
- R6: For a head entry with both split flags at 0, the expected lane mask ((1<<len)-1)<<addr[1:0] must equal the entry's enables exactly. The entry is then retired.
- R7: For a head entry with either split flag at 1, a lane mask that overlaps lanes already accepted, or that includes a lane the entry does not enable, gives check-failed. A passing partial match gives ok without retiring. The entry retires when the accumulated lanes equal its enables.
- R8: Data is compared only in the expected lanes, with expected byte i placed in lane addr[1:0]+i. Store data is always compared. Load data is not compared when the head entry's error flag is set.
- R9: A split-flagged head entry with its error flag set retires on its first passing check. If it is a first half with lane 3 enabled, the next entry must be a second half at address +4; both are retired, and otherwise the result is check-failed.
- R10: A passing check against a head entry whose error flag is set gives bus-error.
- R11: A push while the queue holds DEPTH entries is dropped and sets overflow, which stays at 1 until reset.
- R12: Entries are matched in push order. An expected access compares against the queue as it stood before a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obs_valid | input | 1 | Push an observed access |
| obs_addr | input | 32 | Observed word address (bits [1:0] zero) |
| obs_store | input | 1 | Observed access is a store |
| obs_be | input | 4 | Observed byte enables |
| obs_data | input | 32 | Observed data word |
| obs_err | input | 1 | Observed access got an error response |
| obs_mis_first | input | 1 | First half of a split misaligned access |
| obs_mis_second | input | 1 | Second half of a split misaligned access |
| exp_valid | input | 1 | Present an expected access |
| exp_addr | input | 32 | Expected byte address |
| exp_len | input | 3 | Expected length in bytes |
| exp_store | input | 1 | Expected access is a store |
| exp_data | input | 32 | Expected bytes, byte i in bits [8i+7:8i] |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 ok, 1 check-failed, 2 bus-error |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
Aligned whole-word and sub-word accesses show that the lane mask and the data placement are computed from the byte offset. Single-field mismatches in address, direction, enables and data each show that one comparison alone can fail a check, and a passing retry afterwards shows that the failure retired nothing. Split accesses matched byte by byte tell accumulation apart from single-step retirement, including overlap and out-of-range lanes. Error-flagged pairs, with and without a valid second half and with and without lane 3, separate two-entry retirement from one-entry retirement. A push in the same cycle as a check, an out-of-order check and a fill past the depth cover ordering and overflow.

// File: rtl/dsb_pkg.sv
// Shared types for the data-side scoreboard.
// Assumes a 32-bit address and a 4-lane data word.
package dsb_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_FAIL   = 2'd1,
        RES_BUSERR = 2'd2
    } res_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              store;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
        logic              err;
        logic              mis_first;
        logic              mis_second;
    } obs_ent_t;
endpackage

// File: rtl/dsb_fifo.sv
// In-order queue of observed accesses. Shows the head and the entry behind it,
// and retires zero, one or two entries per cycle.
// Assumes DEPTH is a power of two of at least 2. A push into a full queue is
// dropped, even when a pop happens in the same cycle.
module dsb_fifo
    import dsb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  obs_ent_t      push_ent,
    input  logic [1:0]    pop_cnt,
    output obs_ent_t      head,
    output obs_ent_t      nxt,
    output logic [CW-1:0] count,
    output logic          full
);
    obs_ent_t        mem [DEPTH];
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic            push_ok;

    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign head    = mem[rd_ptr];
    assign nxt     = mem[rd_ptr + AW'(1)];

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_ent;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_cnt);
            count  <= count + CW'(push_ok) - CW'(pop_cnt);
        end
    end

    // R12: never retire more entries than are held
    a_r12_pop_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_cnt) <= count);

    // R11: a push into a full queue without a pop leaves occupancy unchanged
    a_r11_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && pop_cnt == 2'd0) |=> (count == $past(count)));
endmodule

// File: rtl/dsb_match.sv
// Combinational matcher: compares one expected access with the queue head,
// and with the entry behind it for split error pairs. Decides the result,
// the number of entries to retire and the next accumulated lane set.
// Assumes queued addresses are word aligned.
module dsb_match
    import dsb_pkg::*;
(
    input  logic [ADDR_W-1:0] exp_addr,
    input  logic [2:0]        exp_len,
    input  logic              exp_store,
    input  logic [DATA_W-1:0] exp_data,
    input  obs_ent_t          head,
    input  logic              head_vld,
    input  obs_ent_t          nxt,
    input  logic              nxt_vld,
    input  logic [LANES-1:0]  seen,
    output logic              fail,
    output logic              buserr,
    output logic [1:0]        pop_cnt,
    output logic [LANES-1:0]  seen_next
);
    logic [1:0]        off;
    logic              len_ok;
    logic [LANES-1:0]  exp_be;
    logic [DATA_W-1:0] bit_mask, shifted;
    logic              data_ok, mis, pair_ok;
    logic [LANES-1:0]  seen_acc;

    // Lane mask, bit mask and shifted data for the expected access.
    always_comb begin
        off     = exp_addr[1:0];
        len_ok  = (exp_len != 3'd0) && (({2'b00, off} + {1'b0, exp_len}) <= 4'd4);
        shifted = exp_data << {off, 3'b000};
        for (int i = 0; i < LANES; i++) begin
            exp_be[i] = (4'(i) >= {2'b00, off}) && (4'(i) < ({2'b00, off} + {1'b0, exp_len}));
            bit_mask[8*i +: 8] = {8{exp_be[i]}};
        end
        data_ok  = (!exp_store && head.err) || (((shifted ^ head.data) & bit_mask) == '0);
        mis      = head.mis_first || head.mis_second;
        seen_acc = seen | exp_be;
        pair_ok  = nxt_vld && nxt.mis_second && (nxt.addr == head.addr + ADDR_W'(4));
    end

    // Decision chain, in checking order.
    always_comb begin
        fail      = 1'b0;
        buserr    = 1'b0;
        pop_cnt   = 2'd0;
        seen_next = seen;
        if (!head_vld || !len_ok) begin
            fail = 1'b1;
        end else if ((head.addr != {exp_addr[ADDR_W-1:2], 2'b00}) || (head.store != exp_store)) begin
            fail = 1'b1;
        end else if (mis) begin
            if (((exp_be & seen) != '0) || ((exp_be & ~head.be) != '0) || !data_ok) begin
                fail = 1'b1;
            end else if (head.err) begin
                if (head.mis_first && head.be[LANES-1]) begin
                    if (pair_ok) begin
                        pop_cnt = 2'd2;
                        buserr  = 1'b1;
                    end else begin
                        fail = 1'b1;
                    end
                end else begin
                    pop_cnt = 2'd1;
                    buserr  = 1'b1;
                end
            end else if (seen_acc == head.be) begin
                pop_cnt = 2'd1;
            end else begin
                seen_next = seen_acc;
            end
        end else if ((exp_be != head.be) || !data_ok) begin
            fail = 1'b1;
        end else begin
            pop_cnt = 2'd1;
            buserr  = head.err;
        end
        if (pop_cnt != 2'd0) seen_next = '0;
    end

    // R5: a failed check never retires anything
    a_r5_fail_no_pop: assert final (!(fail && pop_cnt != 2'd0));
endmodule

// File: rtl/dside_scoreboard.sv
// Data-side access scoreboard top. Queues observed accesses, checks each
// expected access against the head and registers a one-cycle result strobe.
// Assumes at most one expected access per cycle; results are not back-pressured.
module dside_scoreboard
    import dsb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        obs_valid,
    input  logic [31:0] obs_addr,
    input  logic        obs_store,
    input  logic [3:0]  obs_be,
    input  logic [31:0] obs_data,
    input  logic        obs_err,
    input  logic        obs_mis_first,
    input  logic        obs_mis_second,
    input  logic        exp_valid,
    input  logic [31:0] exp_addr,
    input  logic [2:0]  exp_len,
    input  logic        exp_store,
    input  logic [31:0] exp_data,
    output logic        res_valid,
    output logic [1:0]  res_code,
    output logic        overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    obs_ent_t         in_ent, head, nxt;
    logic [CW-1:0]    count;
    logic             full;
    logic             m_fail, m_buserr;
    logic [1:0]       m_pop, pop_cnt;
    logic [LANES-1:0] seen_q, m_seen;

    assign in_ent  = '{addr: obs_addr, store: obs_store, be: obs_be, data: obs_data,
                       err: obs_err, mis_first: obs_mis_first, mis_second: obs_mis_second};
    assign pop_cnt = exp_valid ? m_pop : 2'd0;

    dsb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(obs_valid), .push_ent(in_ent),
        .pop_cnt(pop_cnt), .head(head), .nxt(nxt), .count(count), .full(full)
    );

    dsb_match u_match (
        .exp_addr(exp_addr), .exp_len(exp_len), .exp_store(exp_store), .exp_data(exp_data),
        .head(head), .head_vld(count != '0), .nxt(nxt), .nxt_vld(count > CW'(1)),
        .seen(seen_q), .fail(m_fail), .buserr(m_buserr), .pop_cnt(m_pop), .seen_next(m_seen)
    );

    // Accumulated lanes of the head entry, advanced only by a check.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= '0;
        else if (exp_valid) seen_q <= m_seen;
    end

    // Registered result strobe and code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= RES_OK;
        end else begin
            res_valid <= exp_valid;
            res_code  <= m_fail ? RES_FAIL : (m_buserr ? RES_BUSERR : RES_OK);
        end
    end

    // Sticky overflow on a dropped push.
    always_ff @(posedge clk) begin
        if (!rst_n)                 overflow <= 1'b0;
        else if (obs_valid && full) overflow <= 1'b1;
    end

    // R2: every check yields a strobe in the next cycle
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid |=> res_valid);
    // R2: no strobe without a check
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_valid |=> !res_valid);
    // R3: a check against an empty queue fails
    a_r3_empty_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_valid && count == '0) |=> (res_code == RES_FAIL));
    // R5: a failed check with no push keeps the occupancy
    a_r5_fail_keeps_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_valid && m_fail && !obs_valid) |=> (count == $past(count)));
    // R11: overflow stays set
    a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/dside_scoreboard_test.sv
module dside_scoreboard_test;
    import dsb_pkg::*;
    localparam int DEPTH = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic obs_valid = 0, obs_store = 0, obs_err = 0, obs_mis_first = 0, obs_mis_second = 0;
    logic [31:0] obs_addr = 0, obs_data = 0;
    logic [3:0]  obs_be = 0;
    logic exp_valid = 0, exp_store = 0;
    logic [31:0] exp_addr = 0, exp_data = 0;
    logic [2:0]  exp_len = 0;
    logic res_valid, overflow;
    logic [1:0] res_code;

    int checks = 0, errors = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    dside_scoreboard #(.DEPTH(DEPTH)) uut (.*);

    // Behavioural reference model
    obs_ent_t mq[$];
    int  m_seen = 0, m_rc = 0;
    bit  m_rv = 0, m_ovf = 0;

    function automatic void model_eval(input logic [31:0] a, input int len, input bit st,
                                       input logic [31:0] d, output int res, output int npop);
        obs_ent_t h;
        int off, be;
        bit mis;
        longint unsigned mask, ed;
        res = 1; npop = 0;
        if (mq.size() == 0) return;
        off = int'(a % 4);
        if (len < 1 || len > 4 || off + len > 4) return;
        h = mq[0];
        if (h.addr != (a & ~32'h3) || h.store != st) return;
        be  = ((1 << len) - 1) << off;
        mis = h.mis_first || h.mis_second;
        if (mis) begin
            if ((be & m_seen) != 0 || (be & ~int'(h.be)) != 0) return;
        end else if (be != int'(h.be)) return;
        if (st || !h.err) begin
            mask = ((64'd1 << (8 * len)) - 1) << (8 * off);
            ed   = (64'(d) << (8 * off)) & mask;
            if (ed != (64'(h.data) & mask)) return;
        end
        if (mis) begin
            if (h.err) begin
                if (h.mis_first && h.be[3]) begin
                    if (mq.size() < 2 || !mq[1].mis_second || mq[1].addr != h.addr + 4) return;
                    npop = 2;
                end else npop = 1;
            end else begin
                m_seen = m_seen | be;
                if (m_seen == int'(h.be)) npop = 1;
            end
        end else npop = 1;
        res = h.err ? 2 : 0;
        if (npop > 0) m_seen = 0;
    endfunction

    always @(posedge clk) begin
        int r, np;
        bit push_ok;
        if (!rst_n) begin
            mq.delete(); m_seen = 0; m_ovf = 0; m_rv = 0; m_rc = 0;
        end else begin
            push_ok = obs_valid && mq.size() < DEPTH;
            if (obs_valid && !push_ok) m_ovf = 1;
            m_rv = exp_valid;
            if (exp_valid) begin
                model_eval(exp_addr, int'(exp_len), exp_store, exp_data, r, np);
                m_rc = r;
                repeat (np) void'(mq.pop_front());
            end
            if (push_ok)
                mq.push_back('{addr: obs_addr, store: obs_store, be: obs_be, data: obs_data,
                               err: obs_err, mis_first: obs_mis_first, mis_second: obs_mis_second});
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (res_valid !== m_rv) begin
                errors++;
                $display("FAIL R2 res_valid actual=%0d expected=%0d", res_valid, m_rv);
            end
            if (m_rv) begin
                checks++;
                if (res_code !== 2'(m_rc)) begin
                    errors++;
                    $display("FAIL %s res_code actual=%0d expected=%0d", tag, res_code, m_rc);
                end
            end
            checks++;
            if (overflow !== m_ovf) begin
                errors++;
                $display("FAIL R11 overflow actual=%0d expected=%0d", overflow, m_ovf);
            end
        end
    end

    task automatic set_obs(input logic [31:0] a, input bit st, input logic [3:0] be,
                           input logic [31:0] d, input bit e, input bit mf, input bit ms);
        obs_valid = 1; obs_addr = a; obs_store = st; obs_be = be; obs_data = d;
        obs_err = e; obs_mis_first = mf; obs_mis_second = ms;
    endtask

    task automatic set_exp(input logic [31:0] a, input int len, input bit st, input logic [31:0] d);
        exp_valid = 1; exp_addr = a; exp_len = 3'(len); exp_store = st; exp_data = d;
    endtask

    task automatic step();
        @(negedge clk);
        obs_valid = 0; exp_valid = 0;
    endtask

    task automatic push(input logic [31:0] a, input bit st, input logic [3:0] be,
                        input logic [31:0] d, input bit e, input bit mf, input bit ms);
        set_obs(a, st, be, d, e, mf, ms); step();
    endtask

    task automatic chk(input logic [31:0] a, input int len, input bit st, input logic [31:0] d);
        set_exp(a, len, st, d); step();
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: idle outputs after reset
        checks++;
        if (res_valid !== 1'b0 || overflow !== 1'b0) begin
            errors++;
            $display("FAIL R1 res_valid/overflow actual=%0d/%0d expected=0/0", res_valid, overflow);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1"; do_reset();
        tag = "R3"; chk(32'h100, 4, 1, 32'h0);

        tag = "R6";
        push(32'h100, 1, 4'hF, 32'hA1B2C3D4, 0, 0, 0); chk(32'h100, 4, 1, 32'hA1B2C3D4);
        push(32'h204, 0, 4'hC, 32'hBEEF0000, 0, 0, 0); chk(32'h206, 2, 0, 32'h0000BEEF);
        push(32'h208, 1, 4'hF, 32'h11223344, 0, 0, 0); chk(32'h208, 2, 1, 32'h3344);
        chk(32'h208, 4, 1, 32'h11223344);

        tag = "R5";
        push(32'h300, 0, 4'h3, 32'h00005566, 0, 0, 0);
        chk(32'h304, 2, 0, 32'h5566); chk(32'h300, 2, 1, 32'h5566); chk(32'h300, 2, 0, 32'h5566);

        tag = "R4";
        push(32'h30C, 1, 4'hF, 32'hCAFEF00D, 0, 0, 0);
        chk(32'h30C, 0, 1, 32'hCAFEF00D); chk(32'h30C, 5, 1, 32'hCAFEF00D);
        chk(32'h30F, 2, 1, 32'hCAFE); chk(32'h30C, 4, 1, 32'hCAFEF00D);

        tag = "R8";
        push(32'h400, 1, 4'hF, 32'h01020304, 0, 0, 0);
        chk(32'h400, 4, 1, 32'h01020305); chk(32'h400, 4, 1, 32'h01020304);
        push(32'h408, 0, 4'h1, 32'h000000AA, 0, 0, 0);
        chk(32'h408, 1, 0, 32'hAB); chk(32'h408, 1, 0, 32'hAA);
        tag = "R10";
        push(32'h404, 0, 4'hF, 32'hDEADBEEF, 1, 0, 0); chk(32'h404, 4, 0, 32'h0);
        push(32'h40C, 1, 4'hF, 32'h12345678, 1, 0, 0);
        chk(32'h40C, 4, 1, 32'h12345679); chk(32'h40C, 4, 1, 32'h12345678);

        tag = "R7";
        push(32'h500, 1, 4'hE, 32'h33221100, 0, 1, 0);
        chk(32'h501, 1, 1, 32'h11); chk(32'h500, 1, 1, 32'h00); chk(32'h502, 1, 1, 32'h22);
        chk(32'h502, 1, 1, 32'h22); chk(32'h503, 1, 1, 32'h33); chk(32'h503, 1, 1, 32'h33);

        tag = "R9";
        push(32'h600, 0, 4'h8, 32'h0, 1, 1, 0); push(32'h604, 0, 4'h1, 32'h0, 1, 0, 1);
        chk(32'h603, 1, 0, 32'h0); chk(32'h604, 1, 0, 32'h0);
        push(32'h610, 0, 4'h8, 32'h0, 1, 1, 0); push(32'h614, 0, 4'hF, 32'h0, 0, 0, 0);
        chk(32'h613, 1, 0, 32'h0);
        do_reset();
        push(32'h620, 0, 4'h8, 32'h0, 1, 1, 0); push(32'h628, 0, 4'h1, 32'h0, 1, 0, 1);
        chk(32'h623, 1, 0, 32'h0);
        do_reset();
        push(32'h630, 0, 4'h6, 32'h0, 1, 1, 0); push(32'h634, 1, 4'hF, 32'h77, 0, 0, 0);
        chk(32'h631, 1, 0, 32'h0); chk(32'h634, 4, 1, 32'h77);

        tag = "R12";
        set_obs(32'h700, 1, 4'hF, 32'h5A5A5A5A, 0, 0, 0); set_exp(32'h700, 4, 1, 32'h5A5A5A5A); step();
        chk(32'h700, 4, 1, 32'h5A5A5A5A);
        push(32'h710, 0, 4'hF, 32'h1, 0, 0, 0); push(32'h714, 0, 4'hF, 32'h2, 0, 0, 0);
        chk(32'h714, 4, 0, 32'h2); chk(32'h710, 4, 0, 32'h1); chk(32'h714, 4, 0, 32'h2);

        tag = "R11";
        for (int k = 0; k < DEPTH + 1; k++) push(32'h1000 + 32'(4 * k), 1, 4'hF, 32'(k), 0, 0, 0);
        for (int k = 0; k < DEPTH + 1; k++) chk(32'h1000 + 32'(4 * k), 4, 1, 32'(k));
        repeat (2) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule